// File: doc/BRIEF.md
# TLB Invalidation Control Unit

This block keeps a small fully associative cache of address translations for each of two translation units and lets a host remove entries from them. The host programs a target mask that picks one or both units, an inclusive address window, and then writes a command word. One command drops every entry of the chosen units at once. The other walks the entries one per clock and drops those whose page touches the window, then raises a sticky completion flag that stays up until the host writes zero to it.

Entries carry one of four page sizes, so the window test compares the whole span of each page, from its tag aligned down to the page size up to the last byte of that page. The block also keeps a table base register aligned to 128 bytes. A fill port loads entries and a lookup port probes them, so that the invalidation can be observed from outside.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset every entry of both units is invalid, and every register reads 0.
- R2: The table base register (index 0) stores write data bits 31:7 only, and bits 6:0 always read 0.
- R3: Writing 0x2 to the command register (index 4) invalidates every entry of the selected units within two cycles of the write, and leaves the completion flag unchanged.
- R4: In the target mask (index 1), bit 0 selects unit 0 and bit 1 selects unit 1. Both bits may be set together. The entries of an unselected unit are never changed by any command.
- R5: Writing 0x1 to the command register starts a scan of one entry per clock over the selected units. The scan invalidates exactly those entries whose page overlaps the inclusive window from the start register (index 2) to the end register (index 3), and it finishes within 12 cycles of the write.
- R6: The page size code of an entry is 0 for 4 KB, 1 for 64 KB, 2 for 1 MB and 3 for 16 MB. An entry covers its tag with the low bits for that size cleared, through its tag with those bits set, and both lookup and window matching use that span.
- R7: The completion register (index 5) reads 1 after a scan ends. Writing a nonzero value to it has no effect. It returns to 0 only when the host writes 0 to it.
- R8: A lookup issued while a scan is running is reported as a miss, even when a valid entry covers the address.
- R9: A fill writes the next slot of its unit in round-robin order, so the ninth fill into a unit overwrites the entry of the first. A fill presented while a scan is running is dropped.
- R10: Any command value other than 0x1 and 0x2 changes no entry and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_re |
| fill_en | input | 1 | Load one entry |
| fill_unit | input | 1 | Unit that receives the fill |
| fill_size | input | 2 | Page size code of the filled entry |
| fill_tag | input | 32 | Address tag of the filled entry |
| lk_req | input | 1 | Lookup strobe |
| lk_unit | input | 1 | Unit that is probed |
| lk_addr | input | 32 | Address that is probed |
| lk_hit | output | 1 | Lookup result, valid one cycle after lk_req |

## Verification
A lookup and a running range scan can fall in the same cycle, and so can a fill and a running scan. The bench starts a scan and, two clocks later, probes an address whose entry lies outside the window. It expects a miss at that point and a hit once the completion flag is up, which shows that the miss came from the scan being busy and not from the entry being removed. A fill placed inside the scan is judged by probing its address after completion and expecting a miss.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic [1:0]    code;
    logic [DW-1:0] tag;
  } tlb_ent_t;

  // Byte offset mask inside a page of the given size
  function automatic logic [DW-1:0] pg_mask(input logic [1:0] code);
    case (code)
      2'd0:    pg_mask = 32'h0000_0FFF;
      2'd1:    pg_mask = 32'h0000_FFFF;
      2'd2:    pg_mask = 32'h000F_FFFF;
      default: pg_mask = 32'h00FF_FFFF;
    endcase
  endfunction

  // True when the page of an entry shares any byte with [lo, hi]
  function automatic logic win_overlap(input tlb_ent_t e,
                                       input logic [DW-1:0] lo,
                                       input logic [DW-1:0] hi);
    logic [DW-1:0] m;
    m = pg_mask(e.code);
    win_overlap = ((e.tag & ~m) <= hi) && ((e.tag | m) >= lo);
  endfunction

  // Register word indices
  localparam logic [2:0] RI_BASE = 3'd0;
  localparam logic [2:0] RI_SEL  = 3'd1;
  localparam logic [2:0] RI_LO   = 3'd2;
  localparam logic [2:0] RI_HI   = 3'd3;
  localparam logic [2:0] RI_CMD  = 3'd4;
  localparam logic [2:0] RI_DONE = 3'd5;

  localparam logic [DW-1:0] CMD_RANGE = 32'h1;
  localparam logic [DW-1:0] CMD_ALL   = 32'h2;
endpackage

// File: rtl/tlbi_regs.sv
module tlbi_regs
  import tlbi_pkg::*;
#(
  parameter int N_UNITS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               re,
  input  logic [2:0]         idx,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic               busy,
  input  logic               done_set,
  output logic [N_UNITS-1:0] sel,
  output logic [DW-1:0]      win_lo,
  output logic [DW-1:0]      win_hi,
  output logic               flush_p,
  output logic               range_p
);
  localparam logic [DW-1:0] BASE_KEEP = 32'hFFFF_FF80;

  logic [DW-1:0] base_q;
  logic          done_q;
  logic          done_clr;

  assign done_clr = we && (idx == RI_DONE) && (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      sel     <= '0;
      win_lo  <= '0;
      win_hi  <= '0;
      flush_p <= 1'b0;
      range_p <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      flush_p <= we && (idx == RI_CMD) && (wdata == CMD_ALL);
      range_p <= we && (idx == RI_CMD) && (wdata == CMD_RANGE) && !busy;
      if (we) begin
        case (idx)
          RI_BASE: base_q <= wdata & BASE_KEEP;
          RI_SEL:  sel    <= wdata[N_UNITS-1:0];
          RI_LO:   win_lo <= wdata;
          RI_HI:   win_hi <= wdata;
          default: ;
        endcase
      end
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      case (idx)
        RI_BASE: rdata <= base_q;
        RI_SEL:  rdata <= DW'(sel);
        RI_LO:   rdata <= win_lo;
        RI_HI:   rdata <= win_hi;
        RI_DONE: rdata <= DW'(done_q);
        default: rdata <= '0;
      endcase
    end
  end

  // R7: the flag drops only on a host write of zero
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q && !done_clr |=> done_q);

  // R2: low base bits never hold data
  a_r2_base_aligned: assert property (@(posedge clk) disable iff (rst)
    we && idx == RI_BASE |=> base_q[6:0] == 7'd0);
endmodule

// File: rtl/tlbi_scan.sv
module tlbi_scan
  import tlbi_pkg::*;
#(
  parameter int N_UNITS = 2,
  parameter int N_ENT   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic [N_UNITS-1:0]       sel_i,
  input  logic [DW-1:0]            lo_i,
  input  logic [DW-1:0]            hi_i,
  output logic                     busy,
  output logic [$clog2(N_ENT)-1:0] pos,
  output logic [N_UNITS-1:0]       unit_en,
  output logic [DW-1:0]            lo,
  output logic [DW-1:0]            hi,
  output logic                     done_p
);
  localparam int IW = $clog2(N_ENT);
  localparam logic [IW-1:0] LAST = IW'(N_ENT - 1);

  assign done_p = busy && (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pos     <= '0;
      unit_en <= '0;
      lo      <= '0;
      hi      <= '0;
    end else if (!busy) begin
      if (go) begin
        busy    <= 1'b1;
        pos     <= '0;
        unit_en <= sel_i;
        lo      <= lo_i;
        hi      <= hi_i;
      end
    end else begin
      pos <= pos + 1'b1;
      if (pos == LAST) busy <= 1'b0;
    end
  end

  // R5: a scan stops right after the last entry
  a_r5_scan_ends: assert property (@(posedge clk) disable iff (rst)
    busy && pos == LAST |=> !busy);

  // R5: a scan once started keeps stepping
  a_r5_scan_steps: assert property (@(posedge clk) disable iff (rst)
    busy && pos != LAST |=> busy && pos == $past(pos) + 1'b1);
endmodule

// File: rtl/tlbi_bank.sv
module tlbi_bank
  import tlbi_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush_all,
  input  logic                     fill_en,
  input  logic [1:0]               fill_code,
  input  logic [DW-1:0]            fill_tag,
  input  logic                     scan_en,
  input  logic [$clog2(N_ENT)-1:0] scan_pos,
  input  logic [DW-1:0]            lo,
  input  logic [DW-1:0]            hi,
  input  logic                     busy,
  input  logic                     lk_req,
  input  logic [DW-1:0]            lk_addr,
  output logic                     lk_hit
);
  localparam int IW = $clog2(N_ENT);

  tlb_ent_t         ent [N_ENT];
  logic [N_ENT-1:0] valid_q;
  logic [IW-1:0]    ptr_q;
  logic [N_ENT-1:0] match;
  logic             fill_ok;
  logic             scan_kill;

  assign fill_ok   = fill_en && !busy && !flush_all;
  assign scan_kill = scan_en && win_overlap(ent[scan_pos], lo, hi);

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      ent[ptr_q].code <= fill_code;
      ent[ptr_q].tag  <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      if (scan_kill) valid_q[scan_pos] <= 1'b0;
      if (fill_ok) begin
        valid_q[ptr_q] <= 1'b1;
        ptr_q          <= ptr_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign match[i] = valid_q[i] &&
      ((lk_addr & ~pg_mask(ent[i].code)) == (ent[i].tag & ~pg_mask(ent[i].code)));
  end

  always_ff @(posedge clk) begin
    if (rst) lk_hit <= 1'b0;
    else     lk_hit <= lk_req && !busy && (|match);
  end

  // R3: an invalidate-all leaves nothing valid
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> valid_q == '0);

  // R9: a fill during a scan changes no valid bit other than by the scan
  a_r9_fill_blocked: assert property (@(posedge clk) disable iff (rst)
    busy && !scan_en && !flush_all |=> valid_q == $past(valid_q));
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl
  import tlbi_pkg::*;
#(
  parameter int N_UNITS = 2,
  parameter int N_ENT   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fill_en,
  input  logic          fill_unit,
  input  logic [1:0]    fill_size,
  input  logic [31:0]   fill_tag,
  input  logic          lk_req,
  input  logic          lk_unit,
  input  logic [31:0]   lk_addr,
  output logic          lk_hit
);
  localparam int IW = $clog2(N_ENT);
  localparam int UW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

  logic [N_UNITS-1:0] sel, unit_en, hit_v;
  logic [DW-1:0]      win_lo, win_hi, scan_lo, scan_hi;
  logic               flush_p, range_p, busy, done_p;
  logic [IW-1:0]      pos;

  tlbi_regs #(.N_UNITS(N_UNITS)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done_set(done_p),
    .sel(sel), .win_lo(win_lo), .win_hi(win_hi),
    .flush_p(flush_p), .range_p(range_p)
  );

  tlbi_scan #(.N_UNITS(N_UNITS), .N_ENT(N_ENT)) scan_i (
    .clk(clk), .rst(rst), .go(range_p), .sel_i(sel), .lo_i(win_lo),
    .hi_i(win_hi), .busy(busy), .pos(pos), .unit_en(unit_en),
    .lo(scan_lo), .hi(scan_hi), .done_p(done_p)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    tlbi_bank #(.N_ENT(N_ENT)) bank_i (
      .clk(clk), .rst(rst),
      .flush_all(flush_p && sel[u]),
      .fill_en(fill_en && (UW'(fill_unit) == UW'(u))),
      .fill_code(fill_size), .fill_tag(fill_tag),
      .scan_en(busy && unit_en[u]), .scan_pos(pos),
      .lo(scan_lo), .hi(scan_hi), .busy(busy),
      .lk_req(lk_req && (UW'(lk_unit) == UW'(u))),
      .lk_addr(lk_addr), .lk_hit(hit_v[u])
    );
  end

  assign lk_hit = |hit_v;

  // R8: probes made during a scan miss
  a_r8_busy_miss: assert property (@(posedge clk) disable iff (rst)
    busy && lk_req |=> !lk_hit);

  // R4: at most one unit answers a probe
  a_r4_one_unit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_v));
endmodule

// File: tb/tlb_inval_ctrl_tb.sv
module tlb_inval_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we, reg_re, fill_en, fill_unit, lk_req, lk_unit, lk_hit;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata, fill_tag, lk_addr;
  logic [1:0]  fill_size;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  tlb_inval_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fill_en(fill_en), .fill_unit(fill_unit), .fill_size(fill_size),
    .fill_tag(fill_tag), .lk_req(lk_req), .lk_unit(lk_unit),
    .lk_addr(lk_addr), .lk_hit(lk_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_idx = i;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  task automatic fill(input logic u, input logic [1:0] s, input logic [31:0] t);
    @(negedge clk); fill_en = 1; fill_unit = u; fill_size = s; fill_tag = t;
    @(negedge clk); fill_en = 0;
  endtask

  task automatic probe(input logic u, input logic [31:0] a, output logic h);
    @(negedge clk); lk_req = 1; lk_unit = u; lk_addr = a;
    @(negedge clk); lk_req = 0; h = lk_hit;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic h;
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d); check("R1 register reset", d, 0);
    end
    probe(0, 32'h0, h); check("R1 unit0 empty", 32'(h), 0);
    probe(1, 32'h0, h); check("R1 unit1 empty", 32'(h), 0);
  endtask

  task automatic t_base;
    logic [31:0] d;
    wr(0, 32'hDEAD_BEEF); rd(0, d); check("R2 base low bits", d, 32'hDEAD_BE80);
    wr(0, 32'h0000_007F); rd(0, d); check("R2 base all low", d, 0);
  endtask

  task automatic t_flush_both;
    logic h; logic [31:0] d;
    fill(0, 0, 32'h0000_1000); fill(1, 1, 32'h0004_0000);
    probe(0, 32'h0000_1ABC, h); check("R6 4K hit", 32'(h), 1);
    probe(1, 32'h0004_FFFF, h); check("R6 64K top hit", 32'(h), 1);
    probe(1, 32'h0005_0000, h); check("R6 64K past end", 32'(h), 0);
    wr(1, 3); wr(4, 2); idle(1);
    probe(0, 32'h0000_1ABC, h); check("R3 unit0 flushed", 32'(h), 0);
    probe(1, 32'h0004_0000, h); check("R3 unit1 flushed", 32'(h), 0);
    rd(5, d); check("R3 no done flag", d, 0);
  endtask

  task automatic t_flush_one;
    logic h;
    fill(0, 2, 32'h0030_0000); fill(1, 2, 32'h0030_0000);
    wr(1, 2); wr(4, 2); idle(1);
    probe(0, 32'h0031_2345, h); check("R4 unit0 kept", 32'(h), 1);
    probe(1, 32'h0031_2345, h); check("R4 unit1 flushed", 32'(h), 0);
    wr(1, 3); wr(4, 2); idle(1);
  endtask

  task automatic t_range;
    logic h; logic [31:0] d;
    fill(0, 0, 32'h0001_0000);
    fill(0, 1, 32'h0002_0000);
    fill(0, 2, 32'h0030_0000);
    fill(0, 3, 32'h0100_0000);
    fill(0, 0, 32'h0000_5000);
    fill(1, 1, 32'h0002_0000);
    wr(1, 1); wr(2, 32'h0002_F000); wr(3, 32'h0030_0000);
    wr(4, 1); idle(12);
    probe(0, 32'h0002_8000, h); check("R5 64K page touched at end", 32'(h), 0);
    probe(0, 32'h0038_0000, h); check("R5 1M page touched at start", 32'(h), 0);
    probe(0, 32'h0001_0800, h); check("R5 4K below window kept", 32'(h), 1);
    probe(0, 32'h0100_0000, h); check("R6 16M above window kept", 32'(h), 1);
    probe(0, 32'h0000_5FFF, h); check("R5 low 4K kept", 32'(h), 1);
    probe(1, 32'h0002_8000, h); check("R4 unselected unit kept", 32'(h), 1);
    rd(5, d); check("R7 done set", d, 1);
    wr(5, 5); rd(5, d); check("R7 nonzero write ignored", d, 1);
    wr(5, 0); rd(5, d); check("R7 zero write clears", d, 0);
  endtask

  task automatic t_busy;
    logic h; logic [31:0] d;
    wr(1, 1); wr(2, 32'h8000_0000); wr(3, 32'h8000_0FFF);
    wr(4, 1); idle(1);
    probe(0, 32'h0001_0800, h); check("R8 lookup during scan", 32'(h), 0);
    fill(0, 0, 32'h0900_0000);
    idle(12);
    rd(5, d); check("R7 second scan done", d, 1);
    probe(0, 32'h0001_0800, h); check("R8 entry still present", 32'(h), 1);
    probe(0, 32'h0900_0000, h); check("R9 fill in scan dropped", 32'(h), 0);
    wr(5, 0);
  endtask

  task automatic t_bad_cmd;
    logic h; logic [31:0] d;
    wr(1, 3); wr(4, 3); wr(4, 0); idle(12);
    probe(0, 32'h0001_0800, h); check("R10 odd command keeps entry", 32'(h), 1);
    rd(5, d); check("R10 odd command no flag", d, 0);
  endtask

  task automatic t_round_robin;
    logic h;
    wr(1, 3); wr(4, 2); idle(1);
    for (int i = 0; i < 9; i++) fill(1, 0, 32'h0010_0000 + 32'(i) * 32'h1000);
    probe(1, 32'h0010_0000, h); check("R9 oldest overwritten", 32'(h), 0);
    probe(1, 32'h0010_1000, h); check("R9 second kept", 32'(h), 1);
    probe(1, 32'h0010_8000, h); check("R9 ninth present", 32'(h), 1);
  endtask

  initial begin
    rst = 1; reg_we = 0; reg_re = 0; reg_idx = 0; reg_wdata = 0;
    fill_en = 0; fill_unit = 0; fill_size = 0; fill_tag = 0;
    lk_req = 0; lk_unit = 0; lk_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_base;
    t_flush_both;
    t_flush_one;
    t_range;
    t_busy;
    t_bad_cmd;
    t_round_robin;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule